// File: doc/BRIEF.md
# Clock Extraction Range-Mode Controller

This block decides whether a clock extraction loop runs in its normal frequency mode or in an extended capture range. Once per recovered channel bit period it receives a strobe, along with a flag that says whether the measured bit-clock frequency lies inside the normal range. A single bit period outside that range moves the loop into extended mode at once. The loop returns to normal mode only after an unbroken run of in-range bit periods.

The length of that run is selected by a 2-bit return-delay code. The code picks a power-of-two count between 64 and 512 bit periods. The code is read on every comparison, so a change applies to a run that is already under way. The frequency measurement and the loop itself sit outside this block. Its only output is the mode select.

Top module: `rcm_range_ctrl`

## Requirements
- R1: The return-delay code `rd_sel` selects the length of the run: 2'b00 gives 64 bit periods, 2'b01 gives 128, 2'b10 gives 256 and 2'b11 gives 512. While in extended mode, the run counter never reaches 512.
- R2: In extended mode (`ext_mode` = 1), `ext_mode` returns to 0 at the clock edge that samples the in-range strobe bringing the consecutive count to the selected delay. It stays 1 on every earlier in-range strobe of that run.
- R3: In extended mode, a strobe with `in_range` = 0 keeps `ext_mode` at 1 and restarts the run. After it, a full selected delay of further in-range strobes is needed.
- R4: In normal mode (`ext_mode` = 0), a strobe with `in_range` = 0 sets `ext_mode` to 1 at the clock edge that samples it.
- R5: In-range strobes seen in normal mode leave `ext_mode` at 0 and add nothing to a later run. After entering extended mode, the full delay is always required.
- R6: On cycles where `bit_stb` = 0, the `in_range` input is ignored and neither the mode nor the run count changes. Idle cycles inside a run therefore do not break it.
- R7: Reset is synchronous and active low. While `rst_n` = 0 is sampled, the block goes to normal mode (`ext_mode` = 0) and the run count is cleared, including a run that was partway through.
- R8: `rd_sel` is compared on every strobe. Lowering it to a delay at or below the run already counted returns the block to normal mode on the next in-range strobe. Raising it lengthens the run still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_stb | input | 1 | One-cycle pulse per recovered channel bit period |
| in_range | input | 1 | 1 when the measured frequency of the current bit period is inside the normal range |
| rd_sel | input | 2 | Return-delay code (64 << rd_sel bit periods) |
| ext_mode | output | 1 | 1 = extended capture range, 0 = normal frequency mode |

## Verification
The bench runs every delay code up to the exact return strobe and checks the strobe just before it. This catches a design that is off by one, or that decodes the code to the wrong length. It breaks runs with an out-of-range strobe near their end, and it scatters idle cycles carrying `in_range` = 0 inside runs. A design that ignored the restart would return early, and one that let non-strobe cycles count or clear the run would also fail. It changes `rd_sel` below and above a run already in progress, and it resets midway through a run. A design that latched the code at entry would exit at the wrong strobe, and one that kept a stale count after reset would exit early. A cycle-by-cycle behavioural model is also compared under long stretches of mixed stimulus.

// File: rtl/rcm_pkg.sv
// Package: shared types and sizing helpers for the range-mode controller.
// Assumes the return delay is a power of two selected by a small code.
package rcm_pkg;

    // Mode of the clock extraction loop as driven on the mode output.
    typedef enum logic {
        MODE_NORMAL   = 1'b0,
        MODE_EXTENDED = 1'b1
    } rcm_mode_t;

    // Number of bits needed to hold the largest delay for a code width.
    function automatic int unsigned rcm_cnt_width(input int unsigned rd_w,
                                                  input int unsigned base_log2);
        return base_log2 + (1 << rd_w);
    endfunction

endpackage

// File: rtl/rcm_delay_decode.sv
// Module: rcm_delay_decode
// Turns the return-delay code into a run length of BASE << code bit periods.
// Assumes CNT_W is wide enough to hold the largest length (checked below).
module rcm_delay_decode #(
    parameter int unsigned RD_W      = 2,
    parameter int unsigned BASE_LOG2 = 6,
    parameter int unsigned CNT_W     = 10
) (
    input  logic [RD_W-1:0]  rd_sel,
    output logic [CNT_W-1:0] limit
);
    localparam int unsigned NCODES = 1 << RD_W;
    localparam int unsigned BASE   = 1 << BASE_LOG2;

    logic [CNT_W-1:0] len_tbl [NCODES];

    // One table entry per code, each doubling the previous length.
    for (genvar gi = 0; gi < NCODES; gi++) begin : g_len
        assign len_tbl[gi] = CNT_W'(BASE << gi);
    end

    // Select the length for the current code (sampled continuously).
    always_comb begin
        limit = len_tbl[rd_sel];
    end

    // Parameter sanity: the largest length must fit in the counter width.
    initial begin
        assert (CNT_W >= BASE_LOG2 + NCODES)
            else $error("rcm_delay_decode: CNT_W too narrow");
    end
endmodule

// File: rtl/rcm_run_counter.sv
// Module: rcm_run_counter
// Counts consecutive in-range bit-period strobes while in extended mode.
// Flags the strobe on which the run reaches the selected length. Assumes
// bit_stb is a single-cycle pulse per bit period.
module rcm_run_counter #(
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned MAX_DELAY = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             in_range,
    input  logic             ext_mode,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] run_cnt,
    output logic             run_done
);
    logic [CNT_W-1:0] cnt_inc;
    logic             good_stb;
    logic             clear_run;

    // Next count if this strobe extends the run, and its qualifiers.
    always_comb begin
        cnt_inc   = run_cnt + CNT_W'(1);
        good_stb  = bit_stb && in_range && ext_mode;
        run_done  = good_stb && (cnt_inc >= limit);
        clear_run = bit_stb && (!ext_mode || !in_range || run_done);
    end

    // Run counter: moves only on strobes, clears on a miss, exit or normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clear_run) begin
            run_cnt <= '0;
        end else if (good_stb) begin
            run_cnt <= cnt_inc;
        end
    end

    // R3: an out-of-range strobe restarts the run.
    p_clear_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !in_range) |=> (run_cnt == '0));

    // R6: no strobe, no count change.
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(run_cnt));

    // R1: the run never reaches the largest delay.
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < CNT_W'(MAX_DELAY));
endmodule

// File: rtl/rcm_mode_ctrl.sv
// Module: rcm_mode_ctrl
// Holds the normal/extended mode. Enters extended mode on any out-of-range
// strobe and leaves it when the run counter reports a completed run.
// Assumes run_done is only raised in extended mode.
module rcm_mode_ctrl
    import rcm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_stb,
    input  logic      in_range,
    input  logic      run_done,
    output rcm_mode_t mode
);
    rcm_mode_t mode_nxt;

    // Next-mode decision, evaluated only on a strobe.
    always_comb begin
        mode_nxt = mode;
        if (bit_stb) begin
            unique case (mode)
                MODE_NORMAL:   if (!in_range) mode_nxt = MODE_EXTENDED;
                MODE_EXTENDED: if (run_done)  mode_nxt = MODE_NORMAL;
                default:       mode_nxt = MODE_NORMAL;
            endcase
        end
    end

    // Mode register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_NORMAL;
        else        mode <= mode_nxt;
    end

    // R4: an out-of-range strobe in normal mode enters extended mode.
    p_enter_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL && bit_stb && !in_range) |=> (mode == MODE_EXTENDED));

    // R3: an out-of-range strobe in extended mode keeps extended mode.
    p_stay_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_EXTENDED && bit_stb && !in_range) |=> (mode == MODE_EXTENDED));

    // R6: no strobe, no mode change.
    p_mode_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(mode));
endmodule

// File: rtl/rcm_range_ctrl.sv
// Module: rcm_range_ctrl (top)
// Range-mode controller for a clock extraction loop: selects extended mode
// on an out-of-range bit period and returns to normal mode after a
// programmable run of consecutive in-range bit periods.
// Assumes bit_stb is one cycle wide and in_range is valid with it.
module rcm_range_ctrl
    import rcm_pkg::*;
#(
    parameter int unsigned RD_W      = 2,
    parameter int unsigned BASE_LOG2 = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_stb,
    input  logic            in_range,
    input  logic [RD_W-1:0] rd_sel,
    output logic            ext_mode
);
    localparam int unsigned CNT_W     = rcm_cnt_width(RD_W, BASE_LOG2);
    localparam int unsigned MAX_LOG2  = BASE_LOG2 + (1 << RD_W) - 1;
    localparam int unsigned MAX_DELAY = 1 << MAX_LOG2;

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] run_cnt;
    logic             run_done;
    rcm_mode_t        mode;

    rcm_delay_decode #(
        .RD_W      (RD_W),
        .BASE_LOG2 (BASE_LOG2),
        .CNT_W     (CNT_W)
    ) decode_i (
        .rd_sel (rd_sel),
        .limit  (limit)
    );

    rcm_run_counter #(
        .CNT_W     (CNT_W),
        .MAX_DELAY (MAX_DELAY)
    ) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .in_range (in_range),
        .ext_mode (ext_mode),
        .limit    (limit),
        .run_cnt  (run_cnt),
        .run_done (run_done)
    );

    rcm_mode_ctrl mode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .in_range (in_range),
        .run_done (run_done),
        .mode     (mode)
    );

    // Drive the mode select output from the mode register.
    always_comb begin
        ext_mode = (mode == MODE_EXTENDED);
    end

    // R2: a completed run with the current code returns to normal mode.
    p_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && bit_stb && in_range && ({1'b0, run_cnt} + 1'b1 >= {1'b0, limit}))
            |=> !ext_mode);

    // R2: an in-range strobe short of the delay stays in extended mode.
    p_no_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && bit_stb && in_range && ({1'b0, run_cnt} + 1'b1 < {1'b0, limit}))
            |=> ext_mode);

    // R5: no run is accumulated while in normal mode.
    p_no_precount_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> (run_cnt == '0));

    // R7: a sampled reset gives normal mode and a cleared count.
    p_reset_state_r7: assert property (@(posedge clk)
        !rst_n |=> (!ext_mode && run_cnt == '0));
endmodule

// File: tb/rcm_range_ctrl_tb_top.sv
// Bench for rcm_range_ctrl: directed scenarios plus a behavioural model
// compared on every clock.
module rcm_range_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic       in_range = 1'b1;
    logic [1:0] rd_sel = 2'b00;
    logic       ext_mode;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    bit  m_ext = 1'b0;
    int  m_cnt = 0;
    string cur_req = "R7";

    always #10 clk = ~clk;  // 50 MHz

    rcm_range_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .in_range (in_range),
        .rd_sel   (rd_sel),
        .ext_mode (ext_mode)
    );

    // Behavioural model: mode flag plus integer run length.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ext = 1'b0;
            m_cnt = 0;
        end else if (bit_stb) begin
            if (!m_ext) begin
                if (!in_range) m_ext = 1'b1;
                m_cnt = 0;
            end else if (!in_range) begin
                m_cnt = 0;
            end else if (m_cnt + 1 >= (64 << rd_sel)) begin
                m_ext = 1'b0;
                m_cnt = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            n_checks++;
            if (ext_mode !== m_ext) begin
                n_fail++;
                $display("FAIL %s model compare: ext_mode=%0b expected=%0b", cur_req, ext_mode, m_ext);
            end
        end
    end

    task automatic step(input logic s, input logic r);
        @(negedge clk);
        bit_stb  = s;
        in_range = r;
    endtask

    task automatic run_in(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b1);
            if (i % 7 == 3) step(1'b0, 1'b0);  // idle cycle inside the run (R6)
        end
    endtask

    task automatic check_mode(input logic exp, input string req);
        step(1'b0, 1'b1);
        n_checks++;
        if (ext_mode !== exp) begin
            n_fail++;
            $display("FAIL %s directed: ext_mode=%0b expected=%0b", req, ext_mode, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(20 * 190000);
        n_fail++;
        $display("FAIL watchdog: ended=0 expected=1");
        finish_run();
    end

    initial begin
        // R7: reset state.
        cur_req = "R7";
        repeat (3) step(1'b0, 1'b0);
        check_mode(1'b0, "R7");
        @(negedge clk); rst_n = 1'b1;

        // R5: in-range strobes in normal mode keep normal mode.
        cur_req = "R5";
        run_in(100);
        check_mode(1'b0, "R5");

        // R4: one out-of-range strobe enters extended mode.
        cur_req = "R4";
        step(1'b1, 1'b0);
        check_mode(1'b1, "R4");

        // R5: no pre-count from the earlier 100 strobes; full 64 needed.
        cur_req = "R5";
        run_in(63);
        check_mode(1'b1, "R5");
        run_in(1);
        check_mode(1'b0, "R2");

        // R6: idle cycles with in_range low in normal mode change nothing.
        cur_req = "R6";
        repeat (20) step(1'b0, 1'b0);
        check_mode(1'b0, "R6");

        // R1, R2, R3: each code, with a restart near the end of the run.
        for (int c = 0; c < 4; c++) begin
            int len;
            len = 64 << c;
            rd_sel = c[1:0];
            cur_req = "R1";
            step(1'b1, 1'b0);
            run_in(len - 1);
            step(1'b1, 1'b0);                 // break just before completion
            check_mode(1'b1, "R3");
            run_in(len - 1);
            check_mode(1'b1, "R2");            // one short of the delay
            run_in(1);
            check_mode(1'b0, "R1");            // exactly len consecutive
        end

        // R8: lowering the code below the run already counted.
        cur_req = "R8";
        rd_sel = 2'b11;
        step(1'b1, 1'b0);
        run_in(200);
        check_mode(1'b1, "R8");
        rd_sel = 2'b00;
        run_in(1);
        check_mode(1'b0, "R8");

        // R8: raising the code lengthens the current run.
        rd_sel = 2'b00;
        step(1'b1, 1'b0);
        run_in(50);
        rd_sel = 2'b01;
        run_in(14);
        check_mode(1'b1, "R8");
        run_in(63);
        check_mode(1'b1, "R8");
        run_in(1);
        check_mode(1'b0, "R8");

        // R7: reset during a run clears both mode and count.
        cur_req = "R7";
        rd_sel = 2'b00;
        step(1'b1, 1'b0);
        run_in(40);
        @(negedge clk); rst_n = 1'b0;
        check_mode(1'b0, "R7");
        @(negedge clk); rst_n = 1'b1;
        step(1'b1, 1'b0);
        run_in(30);
        check_mode(1'b1, "R7");
        run_in(33);
        check_mode(1'b1, "R7");
        run_in(1);
        check_mode(1'b0, "R7");

        // Mixed stimulus against the model.
        cur_req = "R2";
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 999);
            if (i % 1500 == 0) rd_sel = 2'($urandom_range(0, 3));
            step(r < 600, r >= 3);
        end
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        finish_run();
    end
endmodule